// File: doc/BRIEF.md
# Windowed Watchdog Timer with Early Warning

The block supervises software with a 7-bit down-counter that is refreshed by rewriting its value over a small register bus. A free-running prescaler divides the clock by a fixed power of two. A 2-bit select then divides it again by 1, 2, 4 or 8, and each prescaler tick lowers the counter by one. Once software sets the enable bit, the block raises a reset request in three cases: when the counter's top bit clears, when software writes a counter value whose top bit is zero, or when a refresh arrives while the count is still above the programmed window value.

One tick before the timeout, when the counter lands on 0x40, a status flag is raised. This happens whether or not the interrupt is enabled. The interrupt output shows that flag once the set-only interrupt enable is on. The reset request is sticky and stays high until the block itself is reset. Generating the system reset is left to the surrounding logic.

Top module: `win_wdog`

## Requirements
- R1: After reset, a read of offset 0x0 returns 0x7F (counter 0x7F at bits 6:0, enable at bit 7 clear). A read of offset 0x4 returns 0x7F (window at bits 6:0 = 0x7F, prescale select at bits 8:7 = 0, interrupt enable at bit 9 = 0). A read of offset 0x8 returns 0 (flag at bit 0). rst_req_o and irq_o are low.
- R2: With prescale select s (encodings 0..3), the counter decrements by exactly one every 2^(BASE_LOG2+s) clock cycles.
- R3: The counter wraps from 0x00 to 0x7F. While the enable bit is clear, no reset is ever requested.
- R4: Writing 1 to bit 7 at offset 0x0 sets the enable bit. Writing 0 there leaves it set until rst_ni.
- R5: While enabled, a decrement from 0x40 to 0x3F raises rst_req_o.
- R6: While enabled, an accepted write at offset 0x0 whose bit 6 is 0 loads the counter and raises rst_req_o on the same edge.
- R7: While enabled, a write at offset 0x0 made while the counter is above the window raises rst_req_o and leaves the counter unloaded. A write made while the counter is at or below the window reloads it with no request.
- R8: The flag at bit 0 of offset 0x8 is set when a tick moves the counter to 0x40. This happens whatever the state of the interrupt enable.
- R9: Writing 0 to bit 0 at offset 0x8 clears the flag. Writing 1 leaves it unchanged.
- R10: Writing 1 to bit 9 at offset 0x4 sets the interrupt enable, which only rst_ni clears. irq_o equals interrupt enable AND flag.
- R11: Once high, rst_req_o stays high until rst_ni is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | ADDR_W | Byte offset of the register |
| wdata_i | input | DATA_W | Write data |
| rdata_o | output | DATA_W | Combinational read data for addr_i |
| rst_req_o | output | 1 | Sticky system-reset request |
| irq_o | output | 1 | Early-warning interrupt |

## Verification
The bench first targets the window edge. A refresh at a count exactly equal to the window must pass, and a refresh one count above it must fire. A design using the wrong comparison would reset on a legal refresh or let an early one through. It then checks that a rejected refresh does not load the counter, since a design that loads anyway would quietly push out the timeout.

Timeout is checked at the 0x40 to 0x3F step rather than at zero, and the bench also confirms that a disabled counter wraps with no request. The set-only enable, interrupt enable and flag-clear semantics are each written the "wrong" way and then read back. The measured tick period for each prescale select catches a shift of the divider by one place.

// File: rtl/win_wdog_pkg.sv
package win_wdog_pkg;
  localparam int unsigned OFS_CTRL = 'h0;
  localparam int unsigned OFS_CFG  = 'h4;
  localparam int unsigned OFS_STAT = 'h8;

  typedef enum logic [1:0] {
    SEL_CTRL,
    SEL_CFG,
    SEL_STAT,
    SEL_NONE
  } reg_sel_e;
endpackage

// File: rtl/win_wdog_prescaler.sv
module win_wdog_prescaler #(
  parameter int unsigned BASE_LOG2 = 12,
  parameter int unsigned SEL_W     = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [SEL_W-1:0] sel_i,
  output logic             tick_o
);
  localparam int unsigned MAX_SEL = (1 << SEL_W) - 1;
  localparam int unsigned PW      = (BASE_LOG2 + MAX_SEL > 0) ? BASE_LOG2 + MAX_SEL : 1;

  logic [PW-1:0] div_q;
  logic [PW-1:0] mask;

  always_comb begin
    for (int b = 0; b < PW; b++) begin
      mask[b] = (b < int'(BASE_LOG2) + int'(sel_i));
    end
  end

  assign tick_o = ((div_q & mask) == mask);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) div_q <= '0;
    else         div_q <= div_q + 1'b1;
  end

  generate
    if (BASE_LOG2 > 0) begin : g_spaced
      AST_TICK_SPACED: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tick_o && $stable(sel_i) |=> !tick_o); // R2
    end
  endgenerate
endmodule

// File: rtl/win_wdog_regif.sv
module win_wdog_regif
  import win_wdog_pkg::*;
#(
  parameter int unsigned CNT_W  = 7,
  parameter int unsigned SEL_W  = 2,
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic              en_i,
  input  logic              flag_i,
  output logic [CNT_W-1:0]  win_o,
  output logic [SEL_W-1:0]  pre_sel_o,
  output logic              ie_o,
  output logic              wr_ctrl_o,
  output logic              wr_stat_o,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int unsigned EN_BIT  = CNT_W;
  localparam int unsigned PRE_LSB = CNT_W;
  localparam int unsigned IE_BIT  = CNT_W + SEL_W;

  reg_sel_e sel;
  logic [CNT_W-1:0] win_q;
  logic [SEL_W-1:0] pre_q;
  logic             ie_q;
  logic             wr_cfg;

  always_comb begin
    unique case (int'(addr_i))
      OFS_CTRL: sel = SEL_CTRL;
      OFS_CFG:  sel = SEL_CFG;
      OFS_STAT: sel = SEL_STAT;
      default:  sel = SEL_NONE;
    endcase
  end

  assign wr_ctrl_o = wr_en_i && (sel == SEL_CTRL);
  assign wr_cfg    = wr_en_i && (sel == SEL_CFG);
  assign wr_stat_o = wr_en_i && (sel == SEL_STAT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      win_q <= '1;
      pre_q <= '0;
      ie_q  <= 1'b0;
    end else if (wr_cfg) begin
      win_q <= wdata_i[CNT_W-1:0];
      pre_q <= wdata_i[PRE_LSB +: SEL_W];
      ie_q  <= ie_q | wdata_i[IE_BIT];
    end
  end

  always_comb begin
    rdata_o = '0;
    unique case (sel)
      SEL_CTRL: begin
        rdata_o[CNT_W-1:0] = cnt_i;
        rdata_o[EN_BIT]    = en_i;
      end
      SEL_CFG: begin
        rdata_o[CNT_W-1:0]         = win_q;
        rdata_o[PRE_LSB +: SEL_W]  = pre_q;
        rdata_o[IE_BIT]            = ie_q;
      end
      SEL_STAT: rdata_o[0] = flag_i;
      default:  rdata_o = '0;
    endcase
  end

  assign win_o     = win_q;
  assign pre_sel_o = pre_q;
  assign ie_o      = ie_q;

  AST_IE_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ie_q |=> ie_q); // R10
endmodule

// File: rtl/win_wdog_core.sv
module win_wdog_core #(
  parameter int unsigned CNT_W = 7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             wr_ctrl_i,
  input  logic [CNT_W-1:0] wr_cnt_i,
  input  logic             wr_en_bit_i,
  input  logic             wr_stat_i,
  input  logic             wr_flag_bit_i,
  input  logic [CNT_W-1:0] win_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             en_o,
  output logic             flag_o,
  output logic             rst_req_o
);
  localparam logic [CNT_W-1:0] EARLY     = CNT_W'(1) << (CNT_W - 1);
  localparam logic [CNT_W-1:0] PRE_EARLY = EARLY + CNT_W'(1);

  logic [CNT_W-1:0] cnt_q;
  logic en_q, flag_q, req_q;
  logic win_bad, cnt_load, low_bad, timeout, req_set, flag_set;

  assign win_bad  = en_q && (cnt_q > win_i);
  assign cnt_load = wr_ctrl_i && !win_bad;
  assign low_bad  = en_q && cnt_load && !wr_cnt_i[CNT_W-1];
  assign timeout  = en_q && tick_i && !cnt_load && (cnt_q == EARLY);
  assign req_set  = (wr_ctrl_i && win_bad) || low_bad || timeout;
  assign flag_set = tick_i && !cnt_load && (cnt_q == PRE_EARLY);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '1;
      en_q   <= 1'b0;
      flag_q <= 1'b0;
      req_q  <= 1'b0;
    end else begin
      if (cnt_load)    cnt_q <= wr_cnt_i;
      else if (tick_i) cnt_q <= cnt_q - 1'b1;
      en_q  <= en_q | (wr_ctrl_i & wr_en_bit_i);
      req_q <= req_q | req_set;
      // hardware set wins over a same-cycle software clear
      if (flag_set)                         flag_q <= 1'b1;
      else if (wr_stat_i && !wr_flag_bit_i) flag_q <= 1'b0;
    end
  end

  assign cnt_o     = cnt_q;
  assign en_o      = en_q;
  assign flag_o    = flag_q;
  assign rst_req_o = req_q;

  AST_EN_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_q |=> en_q); // R4
  AST_REQ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_q |=> req_q); // R11
  AST_NO_REQ_DISABLED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_q && !req_q |=> !req_q); // R3
  AST_WIN_REJECT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_ctrl_i && en_q && (cnt_q > win_i) && !tick_i |=> req_q && $stable(cnt_q)); // R7
  AST_TIMEOUT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_q && tick_i && !wr_ctrl_i && (cnt_q == EARLY) |=> req_q); // R5
  AST_LOW_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_ctrl_i && en_q && (cnt_q <= win_i) && !wr_cnt_i[CNT_W-1] |=> req_q); // R6
  AST_EARLY_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i && !wr_ctrl_i && (cnt_q == PRE_EARLY) |=> flag_q); // R8
endmodule

// File: rtl/win_wdog.sv
module win_wdog #(
  parameter int unsigned CNT_W     = 7,
  parameter int unsigned BASE_LOG2 = 12,
  parameter int unsigned SEL_W     = 2,
  parameter int unsigned ADDR_W    = 4,
  parameter int unsigned DATA_W    = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              rst_req_o,
  output logic              irq_o
);
  localparam int unsigned EN_BIT = CNT_W;

  logic [CNT_W-1:0] cnt, win;
  logic [SEL_W-1:0] pre_sel;
  logic tick, en, flag, ie, wr_ctrl, wr_stat;

  win_wdog_prescaler #(.BASE_LOG2(BASE_LOG2), .SEL_W(SEL_W)) i_pre (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sel_i  (pre_sel),
    .tick_o (tick)
  );

  win_wdog_regif #(.CNT_W(CNT_W), .SEL_W(SEL_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_regif (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .addr_i    (addr_i),
    .wdata_i   (wdata_i),
    .cnt_i     (cnt),
    .en_i      (en),
    .flag_i    (flag),
    .win_o     (win),
    .pre_sel_o (pre_sel),
    .ie_o      (ie),
    .wr_ctrl_o (wr_ctrl),
    .wr_stat_o (wr_stat),
    .rdata_o   (rdata_o)
  );

  win_wdog_core #(.CNT_W(CNT_W)) i_core (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .tick_i        (tick),
    .wr_ctrl_i     (wr_ctrl),
    .wr_cnt_i      (wdata_i[CNT_W-1:0]),
    .wr_en_bit_i   (wdata_i[EN_BIT]),
    .wr_stat_i     (wr_stat),
    .wr_flag_bit_i (wdata_i[0]),
    .win_i         (win),
    .cnt_o         (cnt),
    .en_o          (en),
    .flag_o        (flag),
    .rst_req_o     (rst_req_o)
  );

  assign irq_o = ie & flag;
endmodule

// File: tb/test_win_wdog.sv
`timescale 1ns/1ps
module test_win_wdog;
  localparam int BASE = 2;
  localparam logic [3:0] A_CTRL = 4'h0, A_CFG = 4'h4, A_STAT = 4'h8;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic wr_en_i = 1'b0;
  logic [3:0] addr_i = A_CTRL;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic rst_req_o, irq_o;

  int n_run = 0;
  int n_fail = 0;

  always #4 clk_i = ~clk_i;

  win_wdog #(.BASE_LOG2(BASE)) i_win_wdog (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o), .rst_req_o(rst_req_o), .irq_o(irq_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic apply_reset();
    @(negedge clk_i);
    rst_ni = 1'b0; wr_en_i = 1'b0; addr_i = A_CTRL; wdata_i = '0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    #1;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] v);
    addr_i = a;
    #1;
    v = rdata_o;
    addr_i = A_CTRL;
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    wr_en_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk_i);
    wr_en_i = 1'b0; addr_i = A_CTRL; wdata_i = '0;
    #1;
  endtask

  task automatic wait_cnt(input logic [6:0] val, output bit found);
    logic [31:0] v;
    found = 1'b0;
    for (int i = 0; i < 4000; i++) begin
      rd(A_CTRL, v);
      if (v[6:0] == val) begin found = 1'b1; break; end
      @(negedge clk_i);
      #1;
    end
  endtask

  task automatic t_reset_state();
    logic [31:0] v;
    apply_reset();
    rd(A_CTRL, v); chk("R1 ctrl", v, 32'h7F);
    rd(A_CFG, v);  chk("R1 cfg", v, 32'h7F);
    rd(A_STAT, v); chk("R1 stat", v, 32'h0);
    chk("R1 rst_req", rst_req_o, 0);
    chk("R1 irq", irq_o, 0);
  endtask

  task automatic t_prescale();
    logic [31:0] v;
    logic [6:0] c0;
    int n;
    apply_reset();
    for (int s = 0; s < 4; s++) begin
      wr(A_CFG, 32'h7F | (s << 7));
      rd(A_CTRL, v); c0 = v[6:0];
      for (int i = 0; i < 100; i++) begin
        @(negedge clk_i); #1; rd(A_CTRL, v);
        if (v[6:0] != c0) break;
      end
      c0 = v[6:0];
      n = 0;
      for (int i = 0; i < 100; i++) begin
        @(negedge clk_i); #1; n++; rd(A_CTRL, v);
        if (v[6:0] != c0) break;
      end
      chk("R2 tick period", n, (1 << BASE) << s);
      chk("R2 step", v[6:0], c0 - 7'd1);
    end
  endtask

  task automatic t_disabled();
    logic [31:0] v;
    bit f;
    apply_reset();
    wait_cnt(7'h40, f);
    rd(A_STAT, v); chk("R8 flag without ie", v[0], 1);
    chk("R10 irq masked", irq_o, 0);
    wait_cnt(7'h3F, f);
    chk("R3 no req disabled", rst_req_o, 0);
    wait_cnt(7'h00, f);
    @(negedge clk_i); #1;
    wait_cnt(7'h7F, f);
    chk("R3 wrap to 7F", f, 1);
    chk("R3 no req after wrap", rst_req_o, 0);
  endtask

  task automatic t_enable_sticky();
    logic [31:0] v;
    apply_reset();
    wr(A_CTRL, 32'hFF);
    rd(A_CTRL, v); chk("R4 enable set", v[7], 1);
    wr(A_CTRL, 32'h7F);
    rd(A_CTRL, v); chk("R4 enable sticky", v[7], 1);
    chk("R4 legal refresh no req", rst_req_o, 0);
  endtask

  task automatic t_flag_irq();
    logic [31:0] v;
    bit f;
    apply_reset();
    wait_cnt(7'h40, f);
    wr(A_STAT, 32'h1);
    rd(A_STAT, v); chk("R9 write 1 keeps flag", v[0], 1);
    wr(A_CFG, 32'h27F);
    chk("R10 irq follows flag", irq_o, 1);
    wr(A_CFG, 32'h07F);
    rd(A_CFG, v); chk("R10 ie sticky", v[9], 1);
    wr(A_STAT, 32'h0);
    rd(A_STAT, v); chk("R9 write 0 clears", v[0], 0);
    chk("R10 irq drops", irq_o, 0);
  endtask

  task automatic t_timeout();
    bit f;
    apply_reset();
    wr(A_CTRL, 32'hFF);
    wait_cnt(7'h40, f);
    chk("R5 no req at 40", rst_req_o, 0);
    wait_cnt(7'h3F, f);
    chk("R5 req at 3F", rst_req_o, 1);
    repeat (20) @(negedge clk_i);
    #1;
    chk("R11 req held", rst_req_o, 1);
    apply_reset();
    chk("R11 req cleared by reset", rst_req_o, 0);
  endtask

  task automatic t_low_write();
    logic [31:0] v;
    apply_reset();
    wr(A_CTRL, 32'hFF);
    wr(A_CTRL, 32'h3F);
    chk("R6 low write req", rst_req_o, 1);
    rd(A_CTRL, v); chk("R6 counter loaded", v[6:0], 7'h3F);
  endtask

  task automatic t_window();
    logic [31:0] v;
    bit f;
    apply_reset();
    wr(A_CTRL, 32'hFF);
    wr(A_CFG, 32'h50);
    wr(A_CTRL, 32'h60);
    chk("R7 early refresh req", rst_req_o, 1);
    rd(A_CTRL, v);
    chk("R7 early refresh not loaded", (v[6:0] >= 7'h7C), 1);
    apply_reset();
    wr(A_CTRL, 32'hFF);
    wr(A_CFG, 32'h50);
    wait_cnt(7'h51, f);
    wr(A_CTRL, 32'h7F);
    chk("R7 one above window req", rst_req_o, 1);
    rd(A_CTRL, v);
    chk("R7 one above not loaded", (v[6:0] == 7'h51 || v[6:0] == 7'h50), 1);
    apply_reset();
    wr(A_CTRL, 32'hFF);
    wr(A_CFG, 32'h50);
    wait_cnt(7'h50, f);
    wr(A_CTRL, 32'h7F);
    chk("R7 at window legal", rst_req_o, 0);
    rd(A_CTRL, v); chk("R7 at window reload", v[6:0], 7'h7F);
  endtask

  initial begin
    #(8 * 150000);
    n_run++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    t_reset_state();
    t_prescale();
    t_disabled();
    t_enable_sticky();
    t_flag_irq();
    t_timeout();
    t_low_write();
    t_window();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule